// File: doc/BRIEF.md
# Parcel Input Channel Controller

This block receives 16-bit parcels from an external device over an asynchronous-style handshake. The device presents a parcel with four parity bits and raises a ready line. The controller latches the parcel, checks its parity and answers with a resume pulse. Four parcels are joined into one 64-bit word. Each finished word goes out on a simple memory-write port at the channel's current address, and that address then steps by one.

Software programs a transfer by writing the limit address first and the current address second. The channel stays active while the two addresses differ and no interrupt is pending. A disconnect from the device ends the transfer and raises the interrupt flag. A parity failure also raises it, together with a sticky parity-error flag. Either event deactivates the channel and discards any partly built word. Clearing the interrupt clears both flags. A parcel that is offered while the channel is inactive waits, unanswered, until the channel becomes active again.

Top module: `parcel_in_chan`

## Requirements
- R1: After reset, irq, par_err, dev_resume and mem_we are 0, curr_addr is 0 and active is 0.
- R2: A pulse on ld_limit loads ld_addr into the limit register, and a pulse on ld_curr loads it into the current address. active is 1 exactly when the current address differs from the limit and irq is 0.
- R3: The first parcel of a word becomes bits 63..48 of the word, the second bits 47..32, the third bits 31..16 and the fourth bits 15..0.
- R4: The cycle after the fourth good parcel is accepted, mem_we is high for one cycle. In that cycle mem_addr equals the current address before the write, and curr_addr has already stepped by one.
- R5: A parcel is accepted on a clock edge where dev_ready is 1, active is 1, dev_disc is 0 and no resume is in flight. A good parcel is answered with dev_resume high for exactly one cycle, in the cycle after it is accepted.
- R6: Parity bit n covers dev_data[4n+3:4n], and each group of five bits must hold an odd number of ones. When a parcel fails this check, no resume is sent, the parcel is dropped, and both par_err and irq go to 1.
- R7: When dev_disc is 1 on an edge, irq is 1 from the next cycle on. Any partly built word is discarded, so the next word starts from its first parcel.
- R8: A ready that arrives while the channel is inactive gets no resume. It is accepted once the channel becomes active again.
- R9: A pulse on irq_clr clears irq and par_err.
- R10: Once curr_addr reaches the limit, no further parcel is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_limit | input | 1 | Load the limit register from ld_addr |
| ld_curr | input | 1 | Load the current address from ld_addr |
| ld_addr | input | ADDR_W | Address value for either load |
| irq_clr | input | 1 | Clear the interrupt and parity-error flags |
| dev_data | input | PARCEL_W | Parcel data from the device |
| dev_par | input | PARCEL_W/GRP_W | Odd parity bits, one per 4-bit group |
| dev_ready | input | 1 | Device offers a parcel (level, held until answered) |
| dev_disc | input | 1 | Device disconnect |
| dev_resume | output | 1 | One-cycle acknowledge of a good parcel |
| mem_we | output | 1 | Word write strobe |
| mem_addr | output | ADDR_W | Word write address |
| mem_wdata | output | PARCEL_W*NPARCEL | Assembled word |
| curr_addr | output | ADDR_W | Current address |
| active | output | 1 | Channel is accepting parcels |
| irq | output | 1 | Interrupt flag |
| par_err | output | 1 | Sticky parity-error flag |

## Verification
A wrong parcel count shows up as a write one parcel early or late. The bench sees it on the very next word, because the written data comes out shifted by a whole parcel. A stale address or limit shows as a wrong mem_addr, or as active holding the wrong value right after the load edge. A parity or disconnect fault that fails to discard the partial word corrupts the first word written after irq_clr. Each word is compared in full against a value the bench builds itself.

// File: rtl/parcel_chan_pkg.sv
package parcel_chan_pkg;
   localparam int unsigned DEF_PARCEL_W = 16;
   localparam int unsigned DEF_GRP_W    = 4;
   localparam int unsigned DEF_NPARCEL  = 4;
   localparam int unsigned DEF_ADDR_W   = 22;
endpackage

// File: rtl/pc_parity_chk.sv
module pc_parity_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned GRP_W  = 4,
   localparam int unsigned NGRP  = DATA_W / GRP_W
) (
   input  logic [DATA_W-1:0] data,
   input  logic [NGRP-1:0]   par,
   output logic              ok
);
   logic [NGRP-1:0] grp_ok;

   generate
      if (DATA_W % GRP_W != 0) begin : g_bad_w
         $error("pc_parity_chk: DATA_W must be a multiple of GRP_W");
      end
      for (genvar g = 0; g < NGRP; g++) begin : g_grp
         // odd count over the group data plus its parity bit
         assign grp_ok[g] = ^{data[g*GRP_W +: GRP_W], par[g]};
      end
   endgenerate

   assign ok = &grp_ok;
endmodule

// File: rtl/pc_word_asm.sv
module pc_word_asm #(
   parameter int unsigned PARCEL_W = 16,
   parameter int unsigned NPARCEL  = 4,
   localparam int unsigned WORD_W  = PARCEL_W * NPARCEL,
   localparam int unsigned CNT_W   = (NPARCEL > 1) ? $clog2(NPARCEL) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush,
   input  logic                push,
   input  logic [PARCEL_W-1:0] din,
   output logic                word_done,
   output logic [WORD_W-1:0]   word
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(NPARCEL - 1);

   logic [CNT_W-1:0]        cnt_q;
   logic [WORD_W-1:0]       sh_q;

   generate
      if (NPARCEL < 2) begin : g_bad_n
         $error("pc_word_asm: NPARCEL must be at least 2");
      end
   endgenerate

   assign word_done = push && (cnt_q == LAST);
   // earlier parcels sit higher; the newest fills the low end
   assign word      = {sh_q[WORD_W-PARCEL_W-1:0], din};

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         cnt_q <= '0;
         sh_q  <= '0;
      end else if (push) begin
         sh_q  <= word;
         cnt_q <= word_done ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/pc_addr_ctl.sv
module pc_addr_ctl #(
   parameter int unsigned ADDR_W = 22
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_limit,
   input  logic              ld_curr,
   input  logic [ADDR_W-1:0] ld_val,
   input  logic              step,
   output logic [ADDR_W-1:0] curr,
   output logic              at_limit
);
   logic [ADDR_W-1:0] lim_q;

   generate
      if (ADDR_W < 2) begin : g_bad_a
         $error("pc_addr_ctl: ADDR_W too small");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lim_q <= '0;
         curr  <= '0;
      end else begin
         if (ld_limit) lim_q <= ld_val;
         if (ld_curr)      curr <= ld_val;
         else if (step)    curr <= curr + 1'b1;
      end
   end

   assign at_limit = (curr == lim_q);
endmodule

// File: rtl/parcel_in_chan.sv
module parcel_in_chan
   import parcel_chan_pkg::*;
#(
   parameter int unsigned PARCEL_W = DEF_PARCEL_W,
   parameter int unsigned GRP_W    = DEF_GRP_W,
   parameter int unsigned NPARCEL  = DEF_NPARCEL,
   parameter int unsigned ADDR_W   = DEF_ADDR_W,
   localparam int unsigned NGRP    = PARCEL_W / GRP_W,
   localparam int unsigned WORD_W  = PARCEL_W * NPARCEL
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ld_limit,
   input  logic                ld_curr,
   input  logic [ADDR_W-1:0]   ld_addr,
   input  logic                irq_clr,
   input  logic [PARCEL_W-1:0] dev_data,
   input  logic [NGRP-1:0]     dev_par,
   input  logic                dev_ready,
   input  logic                dev_disc,
   output logic                dev_resume,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [WORD_W-1:0]   mem_wdata,
   output logic [ADDR_W-1:0]   curr_addr,
   output logic                active,
   output logic                irq,
   output logic                par_err
);
   logic              at_limit;
   logic              par_ok;
   logic              take, good, bad;
   logic              word_done;
   logic [WORD_W-1:0] word;
   logic              flush;

   generate
      if (PARCEL_W % GRP_W != 0) begin : g_bad_grp
         $error("parcel_in_chan: PARCEL_W must divide into groups");
      end
   endgenerate

   pc_addr_ctl #(.ADDR_W(ADDR_W)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_limit (ld_limit),
      .ld_curr  (ld_curr),
      .ld_val   (ld_addr),
      .step     (good && word_done),
      .curr     (curr_addr),
      .at_limit (at_limit)
   );

   pc_parity_chk #(.DATA_W(PARCEL_W), .GRP_W(GRP_W)) u_par (
      .data (dev_data),
      .par  (dev_par),
      .ok   (par_ok)
   );

   assign active = !at_limit && !irq;
   assign take   = dev_ready && active && !dev_resume && !dev_disc;
   assign good   = take && par_ok;
   assign bad    = take && !par_ok;
   assign flush  = dev_disc || bad || irq_clr || ld_curr;

   pc_word_asm #(.PARCEL_W(PARCEL_W), .NPARCEL(NPARCEL)) u_asm (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .push      (good),
      .din       (dev_data),
      .word_done (word_done),
      .word      (word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dev_resume <= 1'b0;
         mem_we     <= 1'b0;
         mem_addr   <= '0;
         mem_wdata  <= '0;
         irq        <= 1'b0;
         par_err    <= 1'b0;
      end else begin
         dev_resume <= good;
         mem_we     <= good && word_done;
         if (good && word_done) begin
            mem_addr  <= curr_addr;
            mem_wdata <= word;
         end
         if (irq_clr) begin
            irq     <= 1'b0;
            par_err <= 1'b0;
         end else begin
            if (dev_disc || bad) irq     <= 1'b1;
            if (bad)             par_err <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/pc_chan_chk.sv
module pc_chan_chk #(
   parameter int unsigned ADDR_W = 22
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dev_ready,
   input logic              dev_disc,
   input logic              irq_clr,
   input logic              ld_curr,
   input logic              dev_resume,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [ADDR_W-1:0] curr_addr,
   input logic              active,
   input logic              irq,
   input logic              par_err
);
   // R5
   resume_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_resume |=> !dev_resume);
   // R5
   resume_needs_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_resume |-> $past(active && dev_ready));
   // R4
   write_steps_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !$past(ld_curr)) |-> (curr_addr == mem_addr + 1'b1));
   // R10
   write_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> $past(active));
   // R7
   disc_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_disc && !irq_clr) |=> irq);
   // R6
   err_implies_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      par_err |-> irq);
   // R9
   clear_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr |=> (!irq && !par_err));
endmodule

bind parcel_in_chan pc_chan_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dev_ready  (dev_ready),
   .dev_disc   (dev_disc),
   .irq_clr    (irq_clr),
   .ld_curr    (ld_curr),
   .dev_resume (dev_resume),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .curr_addr  (curr_addr),
   .active     (active),
   .irq        (irq),
   .par_err    (par_err)
);

// File: tb/tb_parcel_in_chan.sv
module tb_parcel_in_chan;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 22;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_limit = 1'b0, ld_curr = 1'b0;
   logic [AW-1:0] ld_addr = '0;
   logic          irq_clr = 1'b0;
   logic [15:0]   dev_data = '0;
   logic [3:0]    dev_par = '0;
   logic          dev_ready = 1'b0, dev_disc = 1'b0;
   logic          dev_resume, mem_we, active, irq, par_err;
   logic [AW-1:0] mem_addr, curr_addr;
   logic [63:0]   mem_wdata;

   int            n_chk = 0, n_bad = 0, wr_cnt = 0;
   logic [AW-1:0] last_addr;
   logic [63:0]   last_data;
   bit            finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   parcel_in_chan dut (
      .clk(clk), .rst_n(rst_n), .ld_limit(ld_limit), .ld_curr(ld_curr),
      .ld_addr(ld_addr), .irq_clr(irq_clr), .dev_data(dev_data),
      .dev_par(dev_par), .dev_ready(dev_ready), .dev_disc(dev_disc),
      .dev_resume(dev_resume), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .curr_addr(curr_addr), .active(active),
      .irq(irq), .par_err(par_err)
   );

   always @(negedge clk) if (rst_n && mem_we) begin
      wr_cnt++;
      last_addr = mem_addr;
      last_data = mem_wdata;
   end

   function automatic logic [3:0] odd_par(input logic [15:0] d);
      logic [3:0] p;
      for (int n = 0; n < 4; n++) p[n] = ~^d[4*n +: 4];
      return p;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic load(input logic [AW-1:0] lim, input logic [AW-1:0] cur);
      @(negedge clk); ld_limit = 1; ld_addr = lim;
      @(negedge clk); ld_limit = 0; ld_curr = 1; ld_addr = cur;
      @(negedge clk); ld_curr = 0;
   endtask

   task automatic send_parcel(input logic [15:0] d, input logic [3:0] p,
                              output bit acked);
      @(negedge clk); dev_data = d; dev_par = p; dev_ready = 1;
      acked = 0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (dev_resume) begin acked = 1; break; end
      end
      dev_ready = 0;
   endtask

   task automatic send_word(input logic [63:0] w, input string req);
      bit a;
      for (int i = 0; i < 4; i++) begin
         send_parcel(w[63-16*i -: 16], odd_par(w[63-16*i -: 16]), a);
         chk(a, req, a, 1);
      end
      @(negedge clk);
   endtask

   task automatic word_check(input logic [63:0] w, input logic [AW-1:0] a,
                             input int cnt0);
      chk(wr_cnt == cnt0 + 1, "R4 write count", wr_cnt, cnt0 + 1);
      chk(last_addr == a, "R4 write address", last_addr, a);
      chk(last_data == w, "R3 word order", last_data, w);
      chk(curr_addr == a + 1, "R4 address step", curr_addr, a + 1);
   endtask

   task automatic clear_irq();
      @(negedge clk); irq_clr = 1;
      @(negedge clk); irq_clr = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] w;
      logic [AW-1:0] a;
      int c0;
      bit acked, seen;
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(!irq && !par_err && !dev_resume && !mem_we && !active, "R1 flags",
          {irq, par_err, dev_resume, mem_we, active}, 0);
      chk(curr_addr == 0, "R1 address", curr_addr, 0);

      // R2 load and activate
      load(22'd40, 22'd4);
      chk(active == 1, "R2 active after load", active, 1);
      chk(curr_addr == 4, "R2 current address", curr_addr, 4);

      // random words R3 R4 R5
      for (int k = 0; k < 6; k++) begin
         w = {$urandom, $urandom}; a = curr_addr; c0 = wr_cnt;
         send_word(w, "R5 resume");
         word_check(w, a, c0);
      end
      // directed order pattern R3
      w = 64'h1111_2222_3333_4444; a = curr_addr; c0 = wr_cnt;
      send_word(w, "R5 resume");
      word_check(w, a, c0);

      // R6 parity failure mid-word
      send_parcel(16'hABCD, odd_par(16'hABCD), acked);
      chk(acked, "R5 first parcel", acked, 1);
      send_parcel(16'h0F0F, odd_par(16'h0F0F) ^ 4'b0100, acked);
      chk(!acked, "R6 no resume on bad parity", acked, 0);
      chk(par_err && irq && !active, "R6 flags", {par_err, irq, active}, 3'b110);
      // R9 clear
      clear_irq();
      chk(!irq && !par_err, "R9 flags cleared", {irq, par_err}, 0);
      chk(active, "R2 active after clear", active, 1);
      w = {$urandom, $urandom}; a = curr_addr; c0 = wr_cnt;
      send_word(w, "R5 resume");
      word_check(w, a, c0);   // R6 partial word discarded

      // R7 disconnect mid-word
      c0 = wr_cnt;
      send_parcel(16'h1234, odd_par(16'h1234), acked);
      send_parcel(16'h5678, odd_par(16'h5678), acked);
      @(negedge clk); dev_disc = 1;
      @(negedge clk); dev_disc = 0;
      chk(irq && !par_err, "R7 irq on disconnect", {irq, par_err}, 2'b10);
      chk(wr_cnt == c0, "R7 no partial write", wr_cnt, c0);
      clear_irq();
      w = {$urandom, $urandom}; a = curr_addr; c0 = wr_cnt;
      send_word(w, "R5 resume");
      word_check(w, a, c0);

      // R10 stop at limit
      load(curr_addr + 22'd1, curr_addr);
      w = {$urandom, $urandom}; a = curr_addr; c0 = wr_cnt;
      send_word(w, "R5 resume");
      word_check(w, a, c0);
      chk(!active, "R10 inactive at limit", active, 0);
      // R8 held ready while inactive
      @(negedge clk); dev_data = 16'hCAFE; dev_par = odd_par(16'hCAFE); dev_ready = 1;
      seen = 0;
      repeat (6) begin @(negedge clk); if (dev_resume) seen = 1; end
      chk(!seen, "R8 no resume while inactive", seen, 0);
      chk(wr_cnt == c0 + 1, "R10 no write past limit", wr_cnt, c0 + 1);
      @(negedge clk); ld_limit = 1; ld_addr = curr_addr + 22'd1;
      seen = 0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); ld_limit = 0;
         if (dev_resume) begin seen = 1; break; end
      end
      dev_ready = 0;
      chk(seen, "R8 held ready accepted", seen, 1);
      a = curr_addr; c0 = wr_cnt;
      for (int i = 0; i < 3; i++) begin
         logic [15:0] d;
         d = 16'(16'h0101 * (i + 1));
         send_parcel(d, odd_par(d), acked);
      end
      @(negedge clk);
      word_check(64'hCAFE_0101_0202_0303, a, c0);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule